// File: doc/BRIEF.md
# Dual-Section Decade Ripple Counter

This block is a four-bit counter made of two independent sections: a toggle stage (divide by two) driving output `qa`, and a five-state stage (divide by five) driving `qd`, `qc`, `qb`. Each section has its own count input. Each section advances on the high-to-low transition of that input. Both count inputs are asynchronous to the system clock. They pass through a synchronizer and a falling-edge detector, so each transition becomes a single-cycle count enable.

A two-bit link mode sets how the sections connect. They can run separately. In decimal (BCD) order, the toggle stage's falling output steps the five-state stage. In symmetric divide-by-ten order, the five-state stage's falling top bit steps the toggle stage. A chained step happens in the same system clock cycle as the edge that causes it, so the count never passes through a visible intermediate value. Two gated override pairs act at once on the outputs, without waiting for a count edge. One pair forces zero. The other forces nine and takes priority over the first.

Top module: `decade_ripple_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is cleared. After reset `{qd,qc,qb,qa}` reads 0000.
- R2: With `link_mode` = 2'b00 (independent), each falling edge on `cnt_a` inverts `qa`. Each falling edge on `cnt_b` moves `{qd,qc,qb}` one step through 000, 001, 010, 011, 100 and back to 000. An edge on one input leaves the other section unchanged. `link_mode` = 2'b11 behaves the same way.
- R3: With `link_mode` = 2'b01 (decimal), falling edges on `cnt_a` take `{qd,qc,qb,qa}` through the binary values 0 to 9, and the value after 9 is 0. Edges on `cnt_b` have no effect.
- R4: With `link_mode` = 2'b10 (symmetric), falling edges on `cnt_b` take `{qa,qd,qc,qb}` through 0000, 0001, 0010, 0011, 0100, 1000, 1001, 1010, 1011, 1100 and then back to 0000. This makes `qa` high for five counts and low for five. Edges on `cnt_a` have no effect.
- R5: When every bit of `nine_gate` is high, the outputs read `{qd,qc,qb,qa}` = 1001, whatever `clr_gate` holds.
- R6: When every bit of `clr_gate` is high and `nine_gate` is not all high, the outputs read 0000.
- R7: An override shows on the outputs before the next rising clock edge and lasts as long as it is held. Count edges that fall while an override is held are discarded. After release, the count continues from the forced value on the next falling edge.
- R8: An override pair with only some of its bits high has no effect, and counting goes on normally.
- R9: A falling edge on a count input shows on the outputs after exactly SYNC_STAGES+1 rising clock edges. The rising edge of a count input changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_mode | input | 2 | Section linking: 00/11 independent, 01 decimal, 10 symmetric |
| cnt_a | input | 1 | Count input of the toggle section, falling-edge active, asynchronous |
| cnt_b | input | 1 | Count input of the five-state section, falling-edge active, asynchronous |
| clr_gate | input | GATE_W | Force-to-zero pair; acts only when all bits are high |
| nine_gate | input | GATE_W | Force-to-nine pair; acts only when all bits are high, has priority |
| qa | output | 1 | Toggle section output (bit 0 in decimal order) |
| qb | output | 1 | Five-state section bit 0 |
| qc | output | 1 | Five-state section bit 1 |
| qd | output | 1 | Five-state section bit 2 |

## Verification
In independent mode, pulses are sent on one input at a time. A wrongly shared enable would move both sections, so this tells the two sections apart. A full walk of more than ten edges is run in decimal mode and again in symmetric mode. The symmetric walk separates a cascade triggered on `qd` falling from one triggered on `qa` falling, and each walk also shows that the unused input is ignored. The override patterns mix partial pairs, full pairs, both pairs together, and release from nine. These show the priority order, the immediate effect before a clock edge, and the step from nine to zero. An edge-timing check counts the clock edges between a falling input and the output change.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    LINK_NONE = 2'b00,
    LINK_BCD  = 2'b01,
    LINK_BIQ  = 2'b10,
    LINK_ALT  = 2'b11
  } link_e;

  localparam int QUIN_W = 3;
  localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;
  localparam logic [3:0] NINE_CODE = 4'b1001;
  localparam logic [3:0] ZERO_CODE = 4'b0000;

  // Five-state successor; any code beyond the last legal one falls back to zero.
  function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] s);
    if (s < QUIN_LAST) return s + 3'd1;
    return '0;
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= pipe[STAGES-1];
  end

  assign fall = last & ~pipe[STAGES-1];
endmodule

// File: rtl/cascade_router.sv
module cascade_router
  import dcnt_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       a_evt,
  input  logic       b_evt,
  input  logic       hold,
  input  logic       bin_q,
  input  logic       quin_msb,
  output logic       a_step,
  output logic       b_step
);
  link_e link;
  assign link = link_e'(mode);

  always_comb begin
    a_step = 1'b0;
    b_step = 1'b0;
    if (!hold) begin
      unique case (link)
        LINK_BCD: begin
          a_step = a_evt;
          b_step = a_evt & bin_q;
        end
        LINK_BIQ: begin
          b_step = b_evt;
          a_step = b_evt & quin_msb;
        end
        default: begin
          a_step = a_evt;
          b_step = b_evt;
        end
      endcase
    end
  end
endmodule

// File: rtl/div2_stage.sv
module div2_stage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_val,
  input  logic step,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= load_val;
    else if (step) q <= ~q;
  end
endmodule

// File: rtl/div5_stage.sv
module div5_stage
  import dcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [QUIN_W-1:0] load_val,
  input  logic              step,
  output logic [QUIN_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= quin_next(q);
  end
endmodule

// File: rtl/decade_ripple_counter.sv
module decade_ripple_counter
  import dcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GATE_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        link_mode,
  input  logic              cnt_a,
  input  logic              cnt_b,
  input  logic [GATE_W-1:0] clr_gate,
  input  logic [GATE_W-1:0] nine_gate,
  output logic              qa,
  output logic              qb,
  output logic              qc,
  output logic              qd
);
  localparam int N_IN = 2;

  logic [N_IN-1:0]   raw_in;
  logic [N_IN-1:0]   fall;
  logic              nine_hit, zero_hit, hold;
  logic [3:0]        force_val;
  logic              a_step, b_step;
  logic              bin_q;
  logic [QUIN_W-1:0] quin_q;
  logic [3:0]        q_vec;

  assign raw_in = {cnt_b, cnt_a};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .fall (fall[g])
    );
  end

  // Nine outranks zero.
  assign nine_hit  = &nine_gate;
  assign zero_hit  = (&clr_gate) & ~nine_hit;
  assign hold      = nine_hit | zero_hit;
  assign force_val = nine_hit ? NINE_CODE : ZERO_CODE;

  cascade_router u_route (
    .mode     (link_mode),
    .a_evt    (fall[0]),
    .b_evt    (fall[1]),
    .hold     (hold),
    .bin_q    (bin_q),
    .quin_msb (quin_q[QUIN_W-1]),
    .a_step   (a_step),
    .b_step   (b_step)
  );

  div2_stage u_div2 (
    .clk      (clk),
    .rst      (rst),
    .load     (hold),
    .load_val (force_val[0]),
    .step     (a_step),
    .q        (bin_q)
  );

  div5_stage u_div5 (
    .clk      (clk),
    .rst      (rst),
    .load     (hold),
    .load_val (force_val[3:1]),
    .step     (b_step),
    .q        (quin_q)
  );

  // Overrides reach the pins without waiting for a clock edge.
  assign q_vec = hold ? force_val : {quin_q, bin_q};
  assign qa = q_vec[0];
  assign qb = q_vec[1];
  assign qc = q_vec[2];
  assign qd = q_vec[3];
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker
  import dcnt_pkg::*;
#(
  parameter int GATE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        link_mode,
  input logic [GATE_W-1:0] clr_gate,
  input logic [GATE_W-1:0] nine_gate,
  input logic              qa,
  input logic              qb,
  input logic              qc,
  input logic              qd
);
  logic       forced;
  logic [2:0] q5;
  logic [3:0] qv;
  assign forced = (&clr_gate) | (&nine_gate);
  assign q5 = {qd, qc, qb};
  assign qv = {qd, qc, qb, qa};

  // R5
  nine_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (&nine_gate) |-> (qv == 4'b1001));

  // R6
  zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ((&clr_gate) && !(&nine_gate)) |-> (qv == 4'b0000));

  // R2
  quin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!forced && !$past(forced) && !$past(rst) && (q5 != $past(q5)))
      |-> (q5 == quin_next($past(q5))));

  // R3
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (link_mode == 2'b01 && $stable(link_mode) && !forced && !$past(forced)
     && !$past(rst) && ($past(qv) <= 4'd9)) |-> (qv <= 4'd9));

  // R3
  bcd_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (link_mode == 2'b01 && $stable(link_mode) && !forced && !$past(forced)
     && !$past(rst) && (q5 != $past(q5))) |-> ($past(qa) && !qa));

  // R4
  biq_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (link_mode == 2'b10 && $stable(link_mode) && !forced && !$past(forced)
     && !$past(rst) && (qa != $past(qa))) |-> ($past(qd) && q5 == 3'b000));
endmodule

bind decade_ripple_counter dcnt_checker #(.GATE_W(GATE_W)) u_dcnt_chk (
  .clk       (clk),
  .rst       (rst),
  .link_mode (link_mode),
  .clr_gate  (clr_gate),
  .nine_gate (nine_gate),
  .qa        (qa),
  .qb        (qb),
  .qc        (qc),
  .qd        (qd)
);

// File: tb/tb_decade_ripple_counter.sv
module tb_decade_ripple_counter;
  localparam int SYNC = 2;
  localparam int GW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    link_mode = 2'b00;
  logic          cnt_a = 1'b0;
  logic          cnt_b = 1'b0;
  logic [GW-1:0] clr_gate = '0;
  logic [GW-1:0] nine_gate = '0;
  logic          qa, qb, qc, qd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  decade_ripple_counter #(.SYNC_STAGES(SYNC), .GATE_W(GW)) dut (
    .clk(clk), .rst(rst), .link_mode(link_mode), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .clr_gate(clr_gate), .nine_gate(nine_gate),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd)
  );

  function automatic logic [3:0] dcba();
    return {qd, qc, qb, qa};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic pulse(input bit on_b);
    @(negedge clk);
    if (on_b) cnt_b = 1'b1; else cnt_a = 1'b1;
    repeat (4) @(negedge clk);
    if (on_b) cnt_b = 1'b0; else cnt_a = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; link_mode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    pulse(1'b0);
    pulse(1'b1);
    do_reset(2'b00);
    check("R1 reset clears", dcba(), 4'b0000);
  endtask

  task automatic t_independent();
    do_reset(2'b00);
    pulse(1'b0);
    check("R2 A toggles qa only", dcba(), 4'b0001);
    @(negedge clk); cnt_b = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 rising B no effect", dcba(), 4'b0001);
    cnt_b = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 B steps quin only", dcba(), 4'b0011);
    pulse(1'b1); check("R2 quin 010", dcba(), 4'b0101);
    pulse(1'b1); check("R2 quin 011", dcba(), 4'b0111);
    pulse(1'b1); check("R2 quin 100", dcba(), 4'b1001);
    pulse(1'b1); check("R2 quin wrap", dcba(), 4'b0001);
    pulse(1'b0); check("R2 qa back low", dcba(), 4'b0000);
    do_reset(2'b11);
    pulse(1'b1);
    check("R2 mode 11 independent B", dcba(), 4'b0010);
    pulse(1'b0);
    check("R2 mode 11 independent A", dcba(), 4'b0011);
  endtask

  task automatic t_bcd();
    do_reset(2'b01);
    for (int i = 1; i <= 12; i++) begin
      pulse(1'b0);
      check($sformatf("R3 decimal step %0d", i), dcba(), 4'(i % 10));
    end
    pulse(1'b1);
    check("R3 B ignored in decimal", dcba(), 4'd2);
  endtask

  task automatic t_biq();
    do_reset(2'b10);
    for (int i = 1; i <= 11; i++) begin
      logic [3:0] exp;
      int k;
      k = i % 10;
      exp = {(k >= 5) ? 1'b1 : 1'b0, 3'(k % 5)};
      pulse(1'b1);
      check($sformatf("R4 symmetric step %0d", i), {qa, qd, qc, qb}, exp);
    end
    pulse(1'b0);
    check("R4 A ignored in symmetric", {qa, qd, qc, qb}, 4'b0001);
  endtask

  task automatic t_override();
    do_reset(2'b01);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    check("R3 preload three", dcba(), 4'd3);
    @(negedge clk); clr_gate = 2'b11;
    #2 check("R7 zero shows before edge", dcba(), 4'd0);
    pulse(1'b0);
    check("R7 edge during zero dropped", dcba(), 4'd0);
    @(negedge clk); nine_gate = 2'b11;
    #2 check("R5 nine beats zero", dcba(), 4'b1001);
    @(negedge clk); nine_gate = 2'b00;
    #2 check("R6 zero after nine released", dcba(), 4'd0);
    @(negedge clk); clr_gate = 2'b00;
    repeat (3) @(negedge clk);
    check("R7 holds forced value", dcba(), 4'd0);
    pulse(1'b0);
    check("R7 resumes after zero", dcba(), 4'd1);
    @(negedge clk); nine_gate = 2'b11;
    #2 check("R5 nine alone", dcba(), 4'b1001);
    pulse(1'b0);
    check("R7 edge during nine dropped", dcba(), 4'b1001);
    @(negedge clk); nine_gate = 2'b00;
    repeat (2) @(negedge clk);
    check("R7 holds nine after release", dcba(), 4'b1001);
    pulse(1'b0);
    check("R7 nine then wrap to zero", dcba(), 4'd0);
  endtask

  task automatic t_partial();
    do_reset(2'b01);
    @(negedge clk); clr_gate = 2'b01; nine_gate = 2'b10;
    pulse(1'b0);
    check("R8 partial pairs count on", dcba(), 4'd1);
    @(negedge clk); clr_gate = 2'b10; nine_gate = 2'b01;
    pulse(1'b0);
    check("R8 other partial pairs", dcba(), 4'd2);
    @(negedge clk); clr_gate = 2'b00; nine_gate = 2'b00;
  endtask

  task automatic t_latency();
    do_reset(2'b00);
    @(negedge clk); cnt_a = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 rising A no effect", dcba(), 4'd0);
    cnt_a = 1'b0;
    repeat (SYNC) @(negedge clk);
    check("R9 not yet visible", dcba(), 4'd0);
    @(negedge clk);
    check("R9 visible after SYNC+1 edges", dcba(), 4'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_independent();
    t_bcd();
    t_biq();
    t_override();
    t_partial();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule